// File: doc/BRIEF.md
# Three-Level Phase-Shifted PWM Modulator

This block produces the level commands for two three-phase, three-level bridges that share one switching-period timebase. Each of the six legs is driven with a positive, zero or negative level. Within each half period the positive and negative pulses have equal widths, both set by an inner duty. The three legs of a bridge are spaced one third of a period apart. The second bridge uses its own inner duty and lags the first by an outer phase-shift duty.

Each side has a signed duty correction that is added to its commanded inner duty. A neutral-point balancing loop can use this input to nudge the pulse width up or down. The period is given as one sixth of the switching period in clock cycles, so every spacing and centre falls on a whole cycle. At 200 MHz, for example, a sixth of about 1667 cycles gives roughly 20 kHz. All commands are taken only at the start of a period, so a waveform never changes shape partway through a cycle.

Top module: `tl_psm`

## Requirements
- R1: While reset is held, and until the first period starts, every leg outputs O. The first period starts on the first clock edge after reset is released, at count 0.
- R2: Each leg carries a 2-bit code: 2'b01 is P, 2'b00 is O, 2'b10 is N. The code 2'b11 never appears.
- R3: With sixth length `s`, the period is 6s cycles and the half period is h = 3s. In its own local time t, a leg is P for t in [a, a+w) and N for t in [h+a, h+a+w), and O otherwise. Here w = floor(deff·h / 2^DUTY_W) and a = floor((h−w)/2).
- R4: Primary legs B and C lag leg A by 2s and 4s cycles (one and two thirds of the period). The secondary legs are spaced the same way.
- R5: Each secondary leg lags its primary counterpart by p = floor(min(shift, 2^DUTY_W)·h / 2^DUTY_W) cycles, taken modulo the period. The secondary legs use the secondary effective duty.
- R6: The effective duty deff of each side is the commanded duty plus that side's signed correction, saturated to the range 0 to 2^DUTY_W. Commanded values above 2^DUTY_W are therefore limited as well.
- R7: The sixth length, duties, corrections and shift are captured only at the start of a period. Changes partway through a period take effect at the next period.
- R8: An effective duty of 0 holds a leg at O for the whole period. An effective duty of 2^DUTY_W makes a leg P for the whole first half and N for the whole second half of its local period.
- R9: A sixth length of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_len | input | SEG_W | One sixth of the switching period, in cycles |
| duty_pri | input | DUTY_W+1 | Primary inner duty, 2^DUTY_W = 1.0 |
| duty_sec | input | DUTY_W+1 | Secondary inner duty, 2^DUTY_W = 1.0 |
| shift_out | input | DUTY_W+1 | Outer phase-shift duty, as a fraction of the half period |
| corr_pri | input | COR_W | Signed primary duty correction |
| corr_sec | input | COR_W | Signed secondary duty correction |
| lvl_pri | output | 6 | Primary level codes: leg A [1:0], B [3:2], C [5:4] |
| lvl_sec | output | 6 | Secondary level codes: leg A [1:0], B [3:2], C [5:4] |

## Verification
The assertions assume no timing of their own on the inputs: any value may change on any cycle, because only the captured copy shapes a period. The one alignment property expects equal captured widths and zero shift before it compares the two bridges. The stimulus holds each command set over at least two full periods and keeps the sixth length small, so periods stay short. It also includes one zero sixth length, commands above full scale, and corrections that drive the sum past both rails. A directed run changes every command a few cycles into a period, to show that the old shape runs to the end of that period.

// File: rtl/tl_psm.sv
module tl_psm #(
  parameter int SEG_W  = 11,
  parameter int DUTY_W = 10,
  parameter int COR_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SEG_W-1:0]        seg_len,
  input  logic [DUTY_W:0]         duty_pri,
  input  logic [DUTY_W:0]         duty_sec,
  input  logic [DUTY_W:0]         shift_out,
  input  logic signed [COR_W-1:0] corr_pri,
  input  logic signed [COR_W-1:0] corr_sec,
  output logic [5:0]              lvl_pri,
  output logic [5:0]              lvl_sec
);

  localparam int HW    = SEG_W + 2;
  localparam int CNT_W = SEG_W + 3;
  localparam int PW    = DUTY_W + 1 + HW;
  localparam int SW    = ((DUTY_W > COR_W) ? DUTY_W : COR_W) + 3;
  localparam logic [DUTY_W:0] ONE_V = {1'b1, {DUTY_W{1'b0}}};

  function automatic logic [DUTY_W:0] fix_duty(input logic [DUTY_W:0] d,
                                               input logic signed [COR_W-1:0] c);
    logic signed [SW-1:0] s;
    s = $signed(SW'(d)) + SW'(c);
    if (s < 0) return '0;
    if (s > $signed(SW'(ONE_V))) return ONE_V;
    return s[DUTY_W:0];
  endfunction

  logic             run;
  logic [CNT_W-1:0] cnt;
  logic [SEG_W-1:0] seg_q;
  logic [HW-1:0]    w1_q, w2_q, ph_q;

  logic [SEG_W-1:0] seg_eff;
  logic [HW-1:0]    half_n;
  logic [DUTY_W:0]  dp1, dp2, dph;
  logic [PW-1:0]    prod1, prod2, prodp;

  assign seg_eff = (seg_len == '0) ? SEG_W'(1) : seg_len;
  assign half_n  = (HW'(seg_eff) << 1) + HW'(seg_eff);
  assign dp1     = fix_duty(duty_pri, corr_pri);
  assign dp2     = fix_duty(duty_sec, corr_sec);
  assign dph     = (shift_out > ONE_V) ? ONE_V : shift_out;
  assign prod1   = PW'(dp1) * PW'(half_n);
  assign prod2   = PW'(dp2) * PW'(half_n);
  assign prodp   = PW'(dph) * PW'(half_n);

  logic [CNT_W-1:0] half_q, third_q, per_q;
  assign third_q = CNT_W'(seg_q) << 1;
  assign half_q  = third_q + CNT_W'(seg_q);
  assign per_q   = half_q << 1;

  logic load;
  assign load = !run || (cnt == per_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cnt   <= '0;
      seg_q <= '0;
      w1_q  <= '0;
      w2_q  <= '0;
      ph_q  <= '0;
    end else if (load) begin
      run   <= 1'b1;
      cnt   <= '0;
      seg_q <= seg_eff;
      w1_q  <= HW'(prod1 >> DUTY_W);
      w2_q  <= HW'(prod2 >> DUTY_W);
      ph_q  <= HW'(prodp >> DUTY_W);
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  logic [11:0] lvl_all;

  for (genvar g = 0; g < 6; g++) begin : g_leg
    localparam int  K   = g % 3;
    localparam bit  SEC = (g >= 3);
    logic [CNT_W-1:0] off_k, off_raw, off, t, st;
    logic [HW-1:0]    w;
    logic             in_p, in_n;

    assign off_k   = (K == 0) ? '0 : (K == 1) ? third_q : (third_q << 1);
    assign off_raw = off_k + (SEC ? CNT_W'(ph_q) : '0);
    assign off     = (off_raw >= per_q) ? off_raw - per_q : off_raw;
    assign t       = (cnt >= off) ? cnt - off : cnt + per_q - off;
    assign w       = SEC ? w2_q : w1_q;
    assign st      = (half_q - CNT_W'(w)) >> 1;
    assign in_p    = (t >= st) && (t < st + CNT_W'(w));
    assign in_n    = (t >= half_q + st) && (t < half_q + st + CNT_W'(w));
    assign lvl_all[2*g +: 2] = !run ? 2'b00 : in_p ? 2'b01 : in_n ? 2'b10 : 2'b00;

    AST_NO_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_all[2*g +: 2] != 2'b11);                                        // R2
    AST_P_IN_FIRST_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_all[2*g +: 2] == 2'b01) |-> (t < half_q));                     // R3
    AST_N_IN_SECOND_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_all[2*g +: 2] == 2'b10) |-> (t >= half_q && t < per_q));       // R3
  end

  assign lvl_pri = lvl_all[5:0];
  assign lvl_sec = lvl_all[11:6];

  AST_IDLE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (lvl_pri == '0 && lvl_sec == '0));                           // R1
  AST_COUNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < per_q));                                               // R3
  AST_WIDTH_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (CNT_W'(w1_q) <= half_q && CNT_W'(w2_q) <= half_q && CNT_W'(ph_q) <= half_q)); // R6
  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (run && cnt == '0));                                         // R7
  AST_HOLD_MID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(seg_q) && $stable(w1_q) && $stable(w2_q) && $stable(ph_q))); // R7
  AST_SEC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ph_q == '0 && w1_q == w2_q) |-> (lvl_sec == lvl_pri));        // R5
  AST_SEG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (seg_q != '0));                                               // R9

endmodule

// File: tb/tl_psm_tb.sv
`timescale 1ns/1ps
module tl_psm_tb;
  localparam int NV = 8;
  localparam int V_SEG[NV] = '{4, 5, 4, 4, 3, 4, 0, 6};
  localparam int V_D1 [NV] = '{512, 256, 1024, 1000, 1500, 20, 512, 700};
  localparam int V_D2 [NV] = '{512, 768, 0, 600, 300, 512, 512, 300};
  localparam int V_D  [NV] = '{0, 341, 1024, 200, 2000, 0, 100, 900};
  localparam int V_C1 [NV] = '{0, 0, 0, 100, -127, -100, 0, 40};
  localparam int V_C2 [NV] = '{0, 0, 0, -100, 0, 0, 0, -40};
  localparam int V_W1 [NV] = '{6, 3, 12, 12, 9, 0, 1, 13};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [10:0] seg_len = '0;
  logic [10:0] duty_pri = '0, duty_sec = '0, shift_out = '0;
  logic signed [7:0] corr_pri = '0, corr_sec = '0;
  logic [5:0] lvl_pri, lvl_sec;

  always #2.5 clk = ~clk;

  tl_psm u_dut (.clk(clk), .rst_n(rst_n), .seg_len(seg_len), .duty_pri(duty_pri),
                .duty_sec(duty_sec), .shift_out(shift_out), .corr_pri(corr_pri),
                .corr_sec(corr_sec), .lvl_pri(lvl_pri), .lvl_sec(lvl_sec));

  int total = 0, fails = 0;
  bit done = 0, mon_en = 0, saw11 = 0;
  int pcount = 0;
  string cur_tag = "R3";

  int m_run = 0, m_cnt = 0, m_seg = 1, m_w1 = 0, m_w2 = 0, m_ph = 0;

  function automatic int clampd(int v);
    if (v < 0) return 0;
    if (v > 1024) return 1024;
    return v;
  endfunction

  function automatic logic [1:0] ref_lvl(int t, int half, int w);
    int a;
    a = (half - w) / 2;
    if (t >= a && t < a + w) return 2'b01;
    if (t >= half + a && t < half + a + w) return 2'b10;
    return 2'b00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_cnt = 0;
    end else if (m_run == 0 || m_cnt == 6 * m_seg - 1) begin
      m_seg = (seg_len == 0) ? 1 : int'(seg_len);
      m_w1  = clampd(int'(duty_pri) + int'(corr_pri)) * 3 * m_seg / 1024;
      m_w2  = clampd(int'(duty_sec) + int'(corr_sec)) * 3 * m_seg / 1024;
      m_ph  = clampd(int'(shift_out)) * 3 * m_seg / 1024;
      m_cnt = 0; m_run = 1;
    end else begin
      m_cnt = m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (mon_en) begin
      logic [11:0] got, exp_v;
      int per, half;
      per = 6 * m_seg; half = 3 * m_seg;
      got = {lvl_sec, lvl_pri};
      for (int g = 0; g < 6; g++) begin
        int off, t;
        off = 2 * m_seg * (g % 3) + ((g >= 3) ? m_ph : 0);
        t = ((m_cnt - off) % per + per) % per;
        if (m_run == 0) exp_v[2*g +: 2] = 2'b00;
        else exp_v[2*g +: 2] = ref_lvl(t, half, (g >= 3) ? m_w2 : m_w1);
        if (got[2*g +: 2] == 2'b11) saw11 = 1;
      end
      total++;
      if (got !== exp_v) begin
        fails++;
        $display("FAIL %s (R3 R4 R5 legs) cnt=%0d got %b exp %b", cur_tag, m_cnt, got, exp_v);
      end
      if (m_run != 0 && lvl_pri[1:0] == 2'b01) pcount++;
    end
  end

  task automatic check(string tag, int got, int exp_v);
    total++;
    if (got != exp_v) begin
      fails++;
      $display("FAIL %s got %0d exp %0d", tag, got, exp_v);
    end
  endtask

  function automatic string tag_of(int i);
    case (i)
      1: return "R5";
      2: return "R8";
      3: return "R6";
      4: return "R6";
      5: return "R8";
      6: return "R9";
      7: return "R4";
      default: return "R3";
    endcase
  endfunction

  initial begin
    #500000;
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset idle", int'({lvl_sec, lvl_pri}), 0);
    mon_en = 1;
    for (int i = 0; i < NV; i++) begin
      int per;
      per = 6 * ((V_SEG[i] == 0) ? 1 : V_SEG[i]);
      @(negedge clk);
      cur_tag = tag_of(i);
      rst_n = 0;
      seg_len = 11'(V_SEG[i]); duty_pri = 11'(V_D1[i]); duty_sec = 11'(V_D2[i]);
      shift_out = 11'(V_D[i]); corr_pri = 8'(V_C1[i]); corr_sec = 8'(V_C2[i]);
      @(negedge clk);
      check("R1 outputs O in reset", int'({lvl_sec, lvl_pri}), 0);
      rst_n = 1; pcount = 0;
      repeat (per) @(negedge clk);
      #1;
      check({tag_of(i), " R3 P width per period"}, pcount, V_W1[i]);
      repeat (per) @(negedge clk);
    end
    // R7: change every command a few cycles into a period
    @(negedge clk);
    cur_tag = "R7";
    rst_n = 0;
    seg_len = 11'd4; duty_pri = 11'd512; duty_sec = 11'd512; shift_out = 11'd0;
    corr_pri = '0; corr_sec = '0;
    @(negedge clk);
    rst_n = 1; pcount = 0;
    repeat (5) @(negedge clk);
    seg_len = 11'd5; duty_pri = 11'd1024; duty_sec = 11'd1024; shift_out = 11'd300;
    repeat (19) @(negedge clk);
    #1;
    check("R7 old width kept to period end", pcount, 6);
    pcount = 0;
    repeat (30) @(negedge clk);
    #1;
    check("R7 R8 new full width next period", pcount, 15);
    check("R2 code 11 never seen", int'(saw11), 0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule